// File: doc/BRIEF.md
# Transport Stream PID Drop-Map Filter

This block sits on byte-wide MPEG transport stream paths and removes packets by their packet identifier. It holds two independent filter channels. Each channel parses its own input stream into 188-byte packets, pulls the 13-bit PID out of the header, consults a per-channel drop map holding one bit per PID, and then forwards or discards the whole packet. A forwarded packet leaves the block unchanged, header included. A discarded packet produces no output bytes.

Software programs the drop maps through three byte registers. Two index registers choose one map byte and the channel that owns it. A data register reads and writes that byte. Because the data register reads back, software can flip a single PID with a read-modify-write. Each map byte covers eight neighbouring PIDs. After reset every bit is set, so nothing passes until software clears bits for the PIDs it wants.

Top module: `ts_pid_gate`

## Requirements
- R1: After reset, both index registers read 0, every map byte of both channels reads 0xFF, and every packet on either channel is dropped.
- R2: Register select 0 is the low index and holds PID bits [10:3]. Register select 1 is the high index: bits [1:0] hold PID bits [12:11], bit 2 picks channel 0 or 1, and bits [7:3] read back as 0.
- R3: Register select 2 reads and writes the map byte chosen by the index registers. The bit for PID p sits in byte p>>3, at bit position p&7. A write is visible on the next read.
- R4: If a packet's map bit is 1, none of its bytes is emitted. If the bit is 0, all 188 bytes are emitted in order and unchanged, with the start flag only on the first byte.
- R5: Each channel has its own map. Writes aimed at one channel leave the other channel's bytes and filtering unchanged.
- R6: A packet begins only on a byte that carries the start flag and has the value 0x47. A start byte with any other value, and bytes outside a packet, produce no output.
- R7: The PID is bits [4:0] of packet byte 1 followed by all of byte 2. Bits [7:5] of byte 1 have no effect on the decision.
- R8: A start byte that arrives inside a packet begins a new packet. Bytes of the interrupted packet that were already committed stay emitted. An interrupted header emits nothing.
- R9: The map is looked up once per packet, when byte 2 arrives. A change to that PID's bit during the rest of the packet does not alter the current packet.
- R10: A channel whose map is all 0x00 passes every packet. A channel whose map is all 0xFF passes none.
- R11: Idle cycles between input bytes are tolerated, and output order matches input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_reg | input | 2 | Register select: 0 low index, 1 high index, 2 map data |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Read data of the selected register |
| s_valid | input | NUM_FILT | Per-channel input byte valid |
| s_sop | input | NUM_FILT | Per-channel start-of-packet flag |
| s_data | input | 8*NUM_FILT | Per-channel input bytes, channel f at [8f+7:8f] |
| m_valid | output | NUM_FILT | Per-channel output byte valid |
| m_sop | output | NUM_FILT | Per-channel output start flag |
| m_data | output | 8*NUM_FILT | Per-channel output bytes |

## Verification
The bench sweeps every map byte of both channels twice, once for the reset value and once after loading an arithmetic pattern. It then sends packets whose PIDs spread across the whole range. The spare bits of byte 1 carry noise, so a design that takes the wrong PID bits, uses the wrong bit index, or mixes up the two channels forwards the wrong set of packets. Further cases cover a restart inside the header, where a design that does not roll back would leak header bytes, and a restart inside the body. They also cover a start byte that is not 0x47, and a map bit flipped in the middle of a packet, which a design that looks up the map again would turn into a truncated packet. Gapped input checks that the reorder queue keeps bytes in order.

// File: rtl/ts_pid_pkg.sv
package ts_pid_pkg;
  localparam int PID_W  = 13;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = PID_W - 3;
  localparam int HI_W   = IDX_W - BYTE_W;
  localparam int HDR_W  = PID_W - BYTE_W;

  typedef struct packed {
    logic              sop;
    logic [BYTE_W-1:0] data;
  } tsb_t;

  typedef enum logic [1:0] {
    REG_IDX_LO = 2'd0,
    REG_IDX_HI = 2'd1,
    REG_MAP    = 2'd2,
    REG_NONE   = 2'd3
  } hreg_e;

  function automatic logic [PID_W-1:0] pid_from_hdr(input logic [HDR_W-1:0] b1,
                                                     input logic [BYTE_W-1:0] b2);
    return {b1, b2};
  endfunction

  function automatic logic [IDX_W-1:0] map_index(input logic [PID_W-1:0] pid);
    return pid[PID_W-1:3];
  endfunction

  function automatic logic [2:0] map_bit(input logic [PID_W-1:0] pid);
    return pid[2:0];
  endfunction
endpackage

// File: rtl/pidmap_bank.sv
module pidmap_bank
  import ts_pid_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_byte,
  input  logic [PID_W-1:0]  lk_pid,
  output logic              lk_drop
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [BYTE_W-1:0] mem [ENTRIES];
  logic [BYTE_W-1:0] lk_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_byte;
    end
  end

  assign rd_byte = mem[rd_idx];
  assign lk_byte = mem[map_index(lk_pid)];
  assign lk_drop = lk_byte[map_bit(lk_pid)];

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_byte));
endmodule

// File: rtl/ts_hdr_parser.sv
module ts_hdr_parser
  import ts_pid_pkg::*;
#(
  parameter int              PKT_LEN   = 188,
  parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'h47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic              s_sop,
  input  logic [BYTE_W-1:0] s_data,
  output logic [PID_W-1:0]  lk_pid,
  output logic              lk_fire,
  input  logic              lk_drop,
  output logic              q_push,
  output logic              q_abort,
  output logic              q_commit,
  output tsb_t              q_byte,
  output logic              drop_evt
);
  localparam int CNT_W = $clog2(PKT_LEN);

  logic             in_pkt;
  logic             keep;
  logic [CNT_W-1:0] cnt;
  logic [HDR_W-1:0] hdr1;
  logic             start, body, hdr_b1, body_pass;

  assign start     = s_valid && s_sop;
  assign body      = s_valid && !s_sop && in_pkt;
  assign hdr_b1    = body && (cnt == CNT_W'(1));
  assign lk_fire   = body && (cnt == CNT_W'(2));
  assign body_pass = body && (cnt >= CNT_W'(3)) && keep;
  assign lk_pid    = pid_from_hdr(hdr1, s_data);
  assign drop_evt  = lk_fire && lk_drop;

  assign q_byte.sop  = start;
  assign q_byte.data = s_data;
  assign q_abort  = start || drop_evt;
  assign q_push   = (start && (s_data == SYNC_BYTE)) || hdr_b1 ||
                    (lk_fire && !lk_drop) || body_pass;
  assign q_commit = (lk_fire && !lk_drop) || body_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      keep   <= 1'b0;
      cnt    <= '0;
      hdr1   <= '0;
    end else if (start) begin
      in_pkt <= (s_data == SYNC_BYTE);
      keep   <= 1'b0;
      cnt    <= CNT_W'(1);
    end else if (body) begin
      if (hdr_b1)  hdr1 <= s_data[HDR_W-1:0];
      if (lk_fire) keep <= !lk_drop;
      if (cnt == CNT_W'(PKT_LEN - 1)) begin
        in_pkt <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  a_r9_one_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> !lk_fire);

  a_r4_drop_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !q_commit);
endmodule

// File: rtl/egress_queue.sv
module egress_queue
  import ts_pid_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic abort,
  input  logic commit,
  input  tsb_t din,
  output logic out_valid,
  output tsb_t dout
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int PW    = PTR_W + 1;

  tsb_t          mem [DEPTH];
  logic [PW-1:0] wr, cmt, rd, base, occ;

  assign base      = abort ? cmt : wr;
  assign occ       = base - rd;
  assign out_valid = (rd != cmt);
  assign dout      = mem[rd[PTR_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr  <= '0;
      cmt <= '0;
      rd  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) mem[base[PTR_W-1:0]] <= din;
      wr <= base + PW'(push);
      if (commit) cmt <= base + PW'(push);
      if (out_valid) rd <= rd + PW'(1);
    end
  end

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> occ < PW'(DEPTH));
endmodule

// File: rtl/ts_pid_gate.sv
module ts_pid_gate
  import ts_pid_pkg::*;
#(
  parameter int                NUM_FILT  = 2,
  parameter int                PKT_LEN   = 188,
  parameter logic [7:0]        SYNC_BYTE = 8'h47,
  parameter int                Q_DEPTH   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_wr,
  input  logic [1:0]             host_reg,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  input  logic [NUM_FILT-1:0]    s_valid,
  input  logic [NUM_FILT-1:0]    s_sop,
  input  logic [NUM_FILT*8-1:0]  s_data,
  output logic [NUM_FILT-1:0]    m_valid,
  output logic [NUM_FILT-1:0]    m_sop,
  output logic [NUM_FILT*8-1:0]  m_data
);
  localparam int SEL_W    = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1;
  localparam int HI_REG_W = HI_W + SEL_W;

  logic [7:0]          idx_lo;
  logic [HI_REG_W-1:0] idx_hi;
  logic [IDX_W-1:0]    host_idx;
  logic [SEL_W-1:0]    host_sel;
  logic [7:0]          bank_rd [NUM_FILT];

  assign host_idx = {idx_hi[HI_W-1:0], idx_lo};
  assign host_sel = idx_hi[HI_W +: SEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_lo <= '0;
      idx_hi <= '0;
    end else if (host_wr) begin
      if (hreg_e'(host_reg) == REG_IDX_LO) idx_lo <= host_wdata;
      if (hreg_e'(host_reg) == REG_IDX_HI) idx_hi <= host_wdata[HI_REG_W-1:0];
    end
  end

  always_comb begin
    case (hreg_e'(host_reg))
      REG_IDX_LO: host_rdata = idx_lo;
      REG_IDX_HI: host_rdata = {{(8-HI_REG_W){1'b0}}, idx_hi};
      REG_MAP:    host_rdata = bank_rd[host_sel];
      default:    host_rdata = '0;
    endcase
  end

  for (genvar f = 0; f < NUM_FILT; f++) begin : g_chan
    logic [PID_W-1:0] lk_pid;
    logic             lk_fire, lk_drop;
    logic             q_push, q_abort, q_commit, drop_evt, bank_we;
    tsb_t             q_byte, q_out;

    assign bank_we = host_wr && (hreg_e'(host_reg) == REG_MAP) &&
                     (host_sel == SEL_W'(f));

    pidmap_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_we),
      .wr_idx  (host_idx),
      .wr_byte (host_wdata),
      .rd_idx  (host_idx),
      .rd_byte (bank_rd[f]),
      .lk_pid  (lk_pid),
      .lk_drop (lk_drop)
    );

    ts_hdr_parser #(.PKT_LEN(PKT_LEN), .SYNC_BYTE(SYNC_BYTE)) u_parse (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_valid  (s_valid[f]),
      .s_sop    (s_sop[f]),
      .s_data   (s_data[f*8 +: 8]),
      .lk_pid   (lk_pid),
      .lk_fire  (lk_fire),
      .lk_drop  (lk_drop),
      .q_push   (q_push),
      .q_abort  (q_abort),
      .q_commit (q_commit),
      .q_byte   (q_byte),
      .drop_evt (drop_evt)
    );

    egress_queue #(.DEPTH(Q_DEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .abort     (q_abort),
      .commit    (q_commit),
      .din       (q_byte),
      .out_valid (m_valid[f]),
      .dout      (q_out)
    );

    assign m_sop[f]          = q_out.sop;
    assign m_data[f*8 +: 8]  = q_out.data;

    a_r5_other_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel != SEL_W'(f)) |-> !bank_we);
  end

  a_r2_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && hreg_e'(host_reg) == REG_IDX_LO) |=> $stable(idx_lo));
endmodule

// File: tb/ts_pid_gate_tb.sv
module ts_pid_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_reg = 2'd0;
  logic [7:0]  host_wdata = 8'd0;
  wire  [7:0]  host_rdata;
  logic [1:0]  s_valid = 2'b00;
  logic [1:0]  s_sop = 2'b00;
  logic [15:0] s_data = 16'd0;
  wire  [1:0]  m_valid, m_sop;
  wire  [15:0] m_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0] shadow [2][1024];
  logic [8:0] exp0[$], exp1[$], got0[$], got1[$];

  always #4 clk = ~clk;

  ts_pid_gate u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_reg(host_reg),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .s_valid(s_valid),
    .s_sop(s_sop), .s_data(s_data), .m_valid(m_valid), .m_sop(m_sop),
    .m_data(m_data)
  );

  always @(negedge clk) begin
    if (m_valid[0]) got0.push_back({m_sop[0], m_data[7:0]});
    if (m_valid[1]) got1.push_back({m_sop[1], m_data[15:8]});
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int i);
    return 8'((i * 37) ^ (i >> 3) ^ (f * 90) ^ (i >> 7));
  endfunction

  function automatic logic [7:0] byte_of(input int pid, input int tag, input int j);
    if (j == 0) return 8'h47;
    if (j == 1) return {3'(tag), 5'(pid >> 8)};
    if (j == 2) return 8'(pid);
    return 8'(tag * 7 + j * 13);
  endfunction

  task automatic host_write(input logic [1:0] r, input logic [7:0] v);
    @(negedge clk);
    host_reg = r; host_wdata = v; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] r, output logic [7:0] v);
    @(negedge clk);
    host_wr = 1'b0; host_reg = r;
    #1 v = host_rdata;
  endtask

  task automatic set_idx(input int f, input int idx);
    host_write(2'd0, 8'(idx));
    host_write(2'd1, {5'd0, 1'(f), 2'(idx >> 8)});
  endtask

  task automatic map_write(input int f, input int idx, input logic [7:0] v);
    set_idx(f, idx);
    host_write(2'd2, v);
    shadow[f][idx] = v;
  endtask

  task automatic map_read(input int f, input int idx, output logic [7:0] v);
    set_idx(f, idx);
    host_read(2'd2, v);
  endtask

  task automatic drive_byte(input int f, input bit sop, input logic [7:0] d);
    @(negedge clk);
    s_valid[f] = 1'b1; s_sop[f] = sop; s_data[f*8 +: 8] = d;
  endtask

  task automatic gap(input int f);
    @(negedge clk);
    s_valid[f] = 1'b0; s_sop[f] = 1'b0;
  endtask

  task automatic push_exp(input int f, input logic [8:0] v);
    if (f == 0) exp0.push_back(v); else exp1.push_back(v);
  endtask

  task automatic send_pkt(input int f, input int pid, input int tag, input bit gaps, input int cut);
    logic [7:0] b;
    bit pass;
    pass = !shadow[f][pid >> 3][pid & 7];
    for (int j = 0; j < cut; j++) begin
      b = byte_of(pid, tag, j);
      if (pass && cut >= 3) push_exp(f, {(j == 0), b});
      drive_byte(f, (j == 0), b);
      if (gaps && (j % 5 == 0)) gap(f);
    end
    gap(f);
  endtask

  task automatic compare(input int f, input string req);
    int bad, first_g, first_e, ng, ne;
    repeat (16) @(negedge clk);
    bad = 0; first_g = 0; first_e = 0;
    ng = (f == 0) ? got0.size() : got1.size();
    ne = (f == 0) ? exp0.size() : exp1.size();
    check(ng == ne, {req, " byte count"}, ng, ne);
    for (int i = 0; i < ng && i < ne; i++) begin
      logic [8:0] g, e;
      g = (f == 0) ? got0[i] : got1[i];
      e = (f == 0) ? exp0[i] : exp1[i];
      if (g != e && bad == 0) begin first_g = g; first_e = e; end
      if (g != e) bad++;
    end
    check(bad == 0, {req, " byte content"}, first_g, first_e);
    got0.delete(); got1.delete(); exp0.delete(); exp1.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int bad, fb, fe;
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 1024; i++) shadow[f][i] = 8'hFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of registers and maps
    host_read(2'd0, v); check(v == 8'h00, "R1 low index reset", v, 0);
    host_read(2'd1, v); check(v == 8'h00, "R1 high index reset", v, 0);
    for (int f = 0; f < 2; f++) begin
      bad = 0; fb = 0;
      for (int i = 0; i < 1024; i++) begin
        map_read(f, i, v);
        if (v != 8'hFF) begin bad++; fb = v; end
      end
      check(bad == 0, "R1 map bytes after reset", fb, 8'hFF);
    end
    send_pkt(0, 0, 1, 0, 188);
    send_pkt(1, 16'h1FFF, 2, 0, 188);
    compare(0, "R1 drop after reset ch0");
    compare(1, "R1 drop after reset ch1");

    // R2: index register layout
    host_write(2'd0, 8'hA5);
    host_write(2'd1, 8'hFF);
    host_read(2'd0, v); check(v == 8'hA5, "R2 low index readback", v, 8'hA5);
    host_read(2'd1, v); check(v == 8'h07, "R2 high index readback", v, 8'h07);

    // R3 R5: exhaustive pattern load and readback
    for (int f = 0; f < 2; f++)
      for (int i = 0; i < 1024; i++) map_write(f, i, pat(f, i));
    for (int f = 0; f < 2; f++) begin
      bad = 0; fb = 0; fe = 0;
      for (int i = 0; i < 1024; i++) begin
        map_read(f, i, v);
        if (v != pat(f, i)) begin bad++; fb = v; fe = pat(f, i); end
      end
      check(bad == 0, "R3 R5 map readback", fb, fe);
    end

    // R4 R7 R11: PID spread across the range, gapped input on odd packets
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 24; k++)
        send_pkt(f, (k * 613 + f * 29 + 5) % 8192, k, k[0], 188);
      compare(f, "R4 R7 R11 pattern filtering");
    end

    // R3: read-modify-write of one PID bit
    map_read(0, 13'h1ABC >> 3, v);
    map_write(0, 13'h1ABC >> 3, v | 8'(1 << (13'h1ABC & 7)));
    send_pkt(0, 13'h1ABC, 3, 0, 188);
    compare(0, "R3 set bit drops");
    map_read(0, 13'h1ABC >> 3, v);
    map_write(0, 13'h1ABC >> 3, v & ~8'(1 << (13'h1ABC & 7)));
    send_pkt(0, 13'h1ABC, 4, 0, 188);
    compare(0, "R3 cleared bit passes");

    // R6: wrong sync value and stray bytes
    for (int j = 0; j < 188; j++)
      drive_byte(0, (j == 0), (j == 0) ? 8'h46 : byte_of(13'h1ABC, 5, j));
    for (int j = 0; j < 20; j++) drive_byte(0, 1'b0, 8'(j));
    gap(0);
    compare(0, "R6 no sync");

    // R8: restart inside header and inside body
    send_pkt(0, 13'h1ABC, 6, 0, 2);
    send_pkt(0, 13'h1ABC, 7, 0, 188);
    compare(0, "R8 header restart");
    send_pkt(0, 13'h1ABC, 1, 0, 50);
    send_pkt(0, 13'h1ABC, 2, 1, 188);
    compare(0, "R8 body restart");

    // R9: flip the bit in the middle of a packet, both directions
    fork
      send_pkt(0, 13'h1ABC, 3, 0, 188);
      begin
        repeat (20) @(negedge clk);
        map_write(0, 13'h1ABC >> 3, shadow[0][13'h1ABC >> 3] | 8'(1 << (13'h1ABC & 7)));
      end
    join
    compare(0, "R9 pass kept after set");
    fork
      send_pkt(0, 13'h1ABC, 4, 0, 188);
      begin
        repeat (20) @(negedge clk);
        map_write(0, 13'h1ABC >> 3, shadow[0][13'h1ABC >> 3] & ~8'(1 << (13'h1ABC & 7)));
      end
    join
    compare(0, "R9 drop kept after clear");

    // R10: open and closed maps on channel 1, channel 0 untouched (R5)
    for (int i = 0; i < 1024; i++) map_write(1, i, 8'h00);
    for (int k = 0; k < 6; k++) send_pkt(1, (k * 1499 + 7) % 8192, k, 0, 188);
    compare(1, "R10 all open");
    for (int i = 0; i < 1024; i++) map_write(1, i, 8'hFF);
    for (int k = 0; k < 4; k++) send_pkt(1, (k * 2111 + 3) % 8192, k, 0, 188);
    compare(1, "R10 all closed");
    bad = 0; fb = 0; fe = 0;
    for (int i = 0; i < 1024; i += 37) begin
      map_read(0, i, v);
      if (v != shadow[0][i]) begin bad++; fb = v; fe = shadow[0][i]; end
    end
    check(bad == 0, "R5 channel 0 map untouched", fb, fe);
    for (int k = 0; k < 8; k++) send_pkt(0, (k * 997 + 11) % 8192, k, 0, 188);
    compare(0, "R5 channel 0 filtering untouched");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule